// File: doc/BRIEF.md
# Qualified Programmable Event Counter

This block is one programmable performance counter. Each cycle it receives a bank of event groups. Every group is a vector of narrow sub-event lanes, and each lane carries a small per-cycle count. A configuration word picks the group with an event code and picks lanes inside that group with a unit mask. The selected lanes are summed into a per-cycle event number. That number then passes through a qualification stage before it is added to a 48-bit accumulator.

The qualification stage works in one of two ways. With a zero threshold the full per-cycle number is added. With a nonzero threshold the block adds one per cycle, and only in cycles that pass a compare. The compare can be reversed, and it can be reduced to rising transitions only. A privilege filter gates both ways. Software loads the configuration with a single write strobe and can read and write the counter. A wrap of the accumulator sets a sticky flag, and that flag can drive an interrupt line.

Top module: `qual_event_counter`

## Requirements
- R1: The event code picks group g (0 to GROUPS-1). Lane l of group g occupies bits [(g*LANES+l)*LANE_W +: LANE_W] of `evt_in`. Bit l of the unit mask adds lane l into the per-cycle number. A code of GROUPS or above yields zero.
- R2: With a zero threshold, each enabled and privilege-qualified cycle adds the full per-cycle number. The invert and edge bits have no effect in this mode.
- R3: With a nonzero threshold and invert clear, one is added in cycles where the per-cycle number is greater than or equal to the threshold. The counter never rises by more than one per cycle.
- R4: With invert set and a nonzero threshold, one is added in cycles where the per-cycle number is below the threshold.
- R5: With edge set and a nonzero threshold, one is added only in a cycle where the qualified condition is true and was false in the previous cycle.
- R6: Privilege level 0 is counted only when the os enable is set. Levels 1 to 3 are counted only when the usr enable is set. A filtered cycle also counts as a false condition for edge detection.
- R7: A configuration write with both os and usr clear stores both as set.
- R8: A counter write loads `cnt_wdata` at the next edge and drops that cycle's increment. `cnt_rdata` always shows the accumulator.
- R9: A carry out of the 48-bit accumulator sets a sticky overflow flag. `ovf_clr` clears the flag, but a new carry in the same cycle wins. `irq` equals the flag ANDed with the interrupt enable.
- R10: The edge history is cleared on reset, on every configuration write, and in every cycle while the counter is disabled.
- R11: After reset the counter, flag and interrupt are zero and counting is disabled. The counter holds while disabled, and a configuration-write cycle adds nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Load configuration fields |
| cfg_code | input | 8 | Event group select |
| cfg_umask | input | 8 | Lane select mask |
| cfg_thr | input | 8 | Threshold, zero selects sum mode |
| cfg_edge | input | 1 | Count rising transitions only |
| cfg_inv | input | 1 | Reverse the threshold compare |
| cfg_os | input | 1 | Count at privilege level 0 |
| cfg_usr | input | 1 | Count at privilege levels 1 to 3 |
| cfg_ie | input | 1 | Interrupt enable |
| cfg_en | input | 1 | Counter enable |
| evt_in | input | GROUPS*LANES*LANE_W | Per-cycle lane counts of all groups |
| priv_lvl | input | 2 | Current privilege level |
| cnt_we | input | 1 | Load counter value |
| cnt_wdata | input | 48 | Counter load value |
| ovf_clr | input | 1 | Clear overflow flag |
| cnt_rdata | output | 48 | Current counter value |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Overflow interrupt |

## Verification
The bench targets the threshold boundary, where the per-cycle number equals the threshold. A compare off by one would miss those cycles in normal mode and count them in inverted mode. It holds a condition true over many cycles in edge mode, where a design without history would count every cycle, and it rewrites the configuration mid-burst, where a design that keeps stale history would skip the new rising edge. It also loads the counter just below the wrap point and clears the flag in the same cycle as a carry, which shows whether the sticky flag is lost. It writes a configuration with both privilege enables clear, which shows whether the default to both is applied.

// File: rtl/qec_pkg.sv
package qec_pkg;
  localparam int CODE_W = 8;
  localparam int MASK_W = 8;
  localparam int THR_W  = 8;

  typedef struct packed {
    logic [CODE_W-1:0] code;
    logic [MASK_W-1:0] umask;
    logic [THR_W-1:0]  thr;
    logic              edge_m;
    logic              inv;
    logic              os;
    logic              usr;
    logic              ie;
    logic              en;
  } qec_cfg_t;
endpackage

// File: rtl/qec_lane_sum.sv
module qec_lane_sum #(
  parameter int GROUPS = 4,
  parameter int LANES  = 8,
  parameter int LANE_W = 2,
  parameter int CODE_W = 8,
  parameter int SUM_W  = 5
) (
  input  logic [GROUPS*LANES*LANE_W-1:0] evt,
  input  logic [CODE_W-1:0]              code,
  input  logic [LANES-1:0]               mask,
  output logic [SUM_W-1:0]               sum
);
  localparam int GW = LANES * LANE_W;

  logic [GW-1:0]     grp;
  logic [LANE_W-1:0] lane_v [LANES];

  always_comb begin
    grp = '0;
    for (int g = 0; g < GROUPS; g++) begin
      if (code == CODE_W'(g)) grp = evt[g*GW +: GW];
    end
  end

  genvar l;
  generate
    for (l = 0; l < LANES; l++) begin : g_lane
      assign lane_v[l] = mask[l] ? grp[l*LANE_W +: LANE_W] : '0;
    end
  endgenerate

  always_comb begin
    sum = '0;
    for (int i = 0; i < LANES; i++) sum = sum + SUM_W'(lane_v[i]);
  end
endmodule

// File: rtl/qec_qualify.sv
module qec_qualify #(
  parameter int SUM_W = 5,
  parameter int THR_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SUM_W-1:0] sum,
  input  logic [THR_W-1:0] thr,
  input  logic             inv,
  input  logic             edge_m,
  input  logic             os,
  input  logic             usr,
  input  logic [1:0]       priv,
  input  logic             en,
  input  logic             cfg_we,
  output logic [SUM_W-1:0] inc
);
  localparam int CW = (SUM_W > THR_W) ? SUM_W : THR_W;

  logic priv_ok, ge, cond, prev_q;

  always_comb begin
    priv_ok = (priv == 2'd0) ? os : usr;
    ge      = CW'(sum) >= CW'(thr);
    cond    = priv_ok & (ge ^ inv);
    if (!en || cfg_we)      inc = '0;
    else if (thr == '0)     inc = priv_ok ? sum : '0;
    else if (edge_m)        inc = SUM_W'(cond & ~prev_q);
    else                    inc = SUM_W'(cond);
  end

  always_ff @(posedge clk) begin
    if (rst || cfg_we || !en) prev_q <= 1'b0;
    else                      prev_q <= cond;
  end
endmodule

// File: rtl/qec_accum.sv
module qec_accum #(
  parameter int CNT_W = 48,
  parameter int SUM_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SUM_W-1:0] inc,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             clr_flag,
  output logic [CNT_W-1:0] cnt_q,
  output logic             ovf_q,
  output logic             ovf_d
);
  logic [CNT_W:0] total;

  always_comb begin
    total = {1'b0, cnt_q} + (CNT_W+1)'(inc);
    if (wr_en) ovf_d = ovf_q & ~clr_flag;
    else       ovf_d = total[CNT_W] | (ovf_q & ~clr_flag);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      cnt_q <= wr_en ? wr_data : total[CNT_W-1:0];
      ovf_q <= ovf_d;
    end
  end
endmodule

// File: rtl/qual_event_counter.sv
module qual_event_counter
  import qec_pkg::*;
#(
  parameter int GROUPS = 4,
  parameter int LANES  = 8,
  parameter int LANE_W = 2,
  parameter int CNT_W  = 48
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          cfg_we,
  input  logic [CODE_W-1:0]             cfg_code,
  input  logic [MASK_W-1:0]             cfg_umask,
  input  logic [THR_W-1:0]              cfg_thr,
  input  logic                          cfg_edge,
  input  logic                          cfg_inv,
  input  logic                          cfg_os,
  input  logic                          cfg_usr,
  input  logic                          cfg_ie,
  input  logic                          cfg_en,
  input  logic [GROUPS*LANES*LANE_W-1:0] evt_in,
  input  logic [1:0]                    priv_lvl,
  input  logic                          cnt_we,
  input  logic [CNT_W-1:0]              cnt_wdata,
  input  logic                          ovf_clr,
  output logic [CNT_W-1:0]              cnt_rdata,
  output logic                          ovf_flag,
  output logic                          irq
);
  localparam int SUM_W = $clog2(LANES * ((1 << LANE_W) - 1) + 1);

  qec_cfg_t cfg_q, cfg_d;
  logic [SUM_W-1:0] ev_sum, ev_inc;
  logic             ovf_next, irq_q;
  logic             cur_en, cur_ie;
  logic [THR_W-1:0] cur_thr;

  always_comb begin
    cfg_d = cfg_q;
    if (cfg_we) begin
      cfg_d.code   = cfg_code;
      cfg_d.umask  = cfg_umask;
      cfg_d.thr    = cfg_thr;
      cfg_d.edge_m = cfg_edge;
      cfg_d.inv    = cfg_inv;
      cfg_d.os     = cfg_os | ~(cfg_os | cfg_usr);
      cfg_d.usr    = cfg_usr | ~(cfg_os | cfg_usr);
      cfg_d.ie     = cfg_ie;
      cfg_d.en     = cfg_en;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
      irq_q <= 1'b0;
    end else begin
      cfg_q <= cfg_d;
      irq_q <= ovf_next & cfg_d.ie;
    end
  end

  qec_lane_sum #(.GROUPS(GROUPS), .LANES(LANES), .LANE_W(LANE_W),
                 .CODE_W(CODE_W), .SUM_W(SUM_W)) u_sum (
    .evt(evt_in), .code(cfg_q.code), .mask(cfg_q.umask[LANES-1:0]), .sum(ev_sum)
  );

  qec_qualify #(.SUM_W(SUM_W), .THR_W(THR_W)) u_qual (
    .clk(clk), .rst(rst), .sum(ev_sum), .thr(cfg_q.thr), .inv(cfg_q.inv),
    .edge_m(cfg_q.edge_m), .os(cfg_q.os), .usr(cfg_q.usr), .priv(priv_lvl),
    .en(cfg_q.en), .cfg_we(cfg_we), .inc(ev_inc)
  );

  qec_accum #(.CNT_W(CNT_W), .SUM_W(SUM_W)) u_acc (
    .clk(clk), .rst(rst), .inc(ev_inc), .wr_en(cnt_we), .wr_data(cnt_wdata),
    .clr_flag(ovf_clr), .cnt_q(cnt_rdata), .ovf_q(ovf_flag), .ovf_d(ovf_next)
  );

  assign irq     = irq_q;
  assign cur_en  = cfg_q.en;
  assign cur_ie  = cfg_q.ie;
  assign cur_thr = cfg_q.thr;
endmodule

// File: rtl/qec_checker.sv
module qec_checker #(
  parameter int CNT_W = 48,
  parameter int THR_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_we,
  input logic             cnt_we,
  input logic [CNT_W-1:0] cnt_wdata,
  input logic             ovf_clr,
  input logic [CNT_W-1:0] cnt_rdata,
  input logic             ovf_flag,
  input logic             irq,
  input logic             en_q,
  input logic             ie_q,
  input logic [THR_W-1:0] thr_q
);
  p_irq_follows_r9: assert property (@(posedge clk) disable iff (rst)
    irq == (ovf_flag && ie_q));

  p_flag_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (ovf_flag && !ovf_clr) |=> ovf_flag);

  p_write_loads_r8: assert property (@(posedge clk) disable iff (rst)
    cnt_we |=> (cnt_rdata == $past(cnt_wdata)));

  p_hold_disabled_r11: assert property (@(posedge clk) disable iff (rst)
    (!en_q && !cnt_we && !cfg_we) |=> $stable(cnt_rdata));

  p_single_step_r3: assert property (@(posedge clk) disable iff (rst)
    (en_q && thr_q != '0 && !cnt_we && !cfg_we) |=>
      ((cnt_rdata - $past(cnt_rdata)) <= CNT_W'(1)));
endmodule

bind qual_event_counter qec_checker #(.CNT_W(CNT_W), .THR_W(qec_pkg::THR_W)) u_chk (
  .clk(clk), .rst(rst), .cfg_we(cfg_we), .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
  .ovf_clr(ovf_clr), .cnt_rdata(cnt_rdata), .ovf_flag(ovf_flag), .irq(irq),
  .en_q(cur_en), .ie_q(cur_ie), .thr_q(cur_thr)
);

// File: tb/qual_event_counter_test.sv
module qual_event_counter_test;
  localparam int GROUPS = 4;
  localparam int LANES  = 8;
  localparam int LANE_W = 2;
  localparam int CNT_W  = 48;
  localparam int EW     = GROUPS * LANES * LANE_W;

  logic clk = 0, rst = 1;
  logic cfg_we = 0, cfg_edge = 0, cfg_inv = 0, cfg_os = 0, cfg_usr = 0, cfg_ie = 0, cfg_en = 0;
  logic [7:0] cfg_code = 0, cfg_umask = 0, cfg_thr = 0;
  logic [EW-1:0] evt_in = '0;
  logic [1:0] priv_lvl = 0;
  logic cnt_we = 0, ovf_clr = 0;
  logic [CNT_W-1:0] cnt_wdata = '0;
  logic [CNT_W-1:0] cnt_rdata;
  logic ovf_flag, irq;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  // bench model state
  logic [7:0] m_code = 0, m_umask = 0, m_thr = 0;
  bit m_edge = 0, m_inv = 0, m_os = 0, m_usr = 0, m_ie = 0, m_en = 0, m_prev = 0, m_ovf = 0, m_irq = 0;
  logic [CNT_W-1:0] m_cnt = '0;

  always #2 clk = ~clk;

  qual_event_counter #(.GROUPS(GROUPS), .LANES(LANES), .LANE_W(LANE_W), .CNT_W(CNT_W)) uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_code(cfg_code), .cfg_umask(cfg_umask),
    .cfg_thr(cfg_thr), .cfg_edge(cfg_edge), .cfg_inv(cfg_inv), .cfg_os(cfg_os),
    .cfg_usr(cfg_usr), .cfg_ie(cfg_ie), .cfg_en(cfg_en), .evt_in(evt_in),
    .priv_lvl(priv_lvl), .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .ovf_clr(ovf_clr),
    .cnt_rdata(cnt_rdata), .ovf_flag(ovf_flag), .irq(irq)
  );

  function automatic int lane_total(logic [EW-1:0] e, logic [7:0] code, logic [7:0] um);
    int s = 0;
    if (code < GROUPS)
      for (int l = 0; l < LANES; l++)
        if (um[l]) s += int'(e[(int'(code)*LANES + l)*LANE_W +: LANE_W]);
    return s;
  endfunction

  // advance model by one edge using the currently driven inputs, then compare
  task automatic step(string tag);
    int s, inc;
    bit pok, cnd, carry;
    logic [CNT_W:0] tot;
    s   = lane_total(evt_in, m_code, m_umask);
    pok = (priv_lvl == 0) ? m_os : m_usr;
    cnd = pok && ((s >= int'(m_thr)) ^ m_inv);
    inc = 0;
    if (m_en && !cfg_we) begin
      if (m_thr == 0)   inc = pok ? s : 0;
      else if (m_edge)  inc = (cnd && !m_prev) ? 1 : 0;
      else              inc = cnd ? 1 : 0;
    end
    tot   = {1'b0, m_cnt} + (CNT_W+1)'(inc);
    carry = !cnt_we && tot[CNT_W];
    m_prev = (cfg_we || !m_en) ? 0 : cnd;
    m_cnt  = cnt_we ? cnt_wdata : tot[CNT_W-1:0];
    m_ovf  = carry || (m_ovf && !ovf_clr);
    if (cfg_we) begin
      m_code = cfg_code; m_umask = cfg_umask; m_thr = cfg_thr;
      m_edge = cfg_edge; m_inv = cfg_inv; m_ie = cfg_ie; m_en = cfg_en;
      m_os  = cfg_os  || !(cfg_os || cfg_usr);
      m_usr = cfg_usr || !(cfg_os || cfg_usr);
    end
    m_irq = m_ovf && m_ie;
    @(posedge clk); #1;
    n_tests++;
    if (cnt_rdata !== m_cnt || ovf_flag !== m_ovf || irq !== m_irq) begin
      n_fail++;
      $display("FAIL %s: cnt=%0h ovf=%0b irq=%0b expected cnt=%0h ovf=%0b irq=%0b",
               tag, cnt_rdata, ovf_flag, irq, m_cnt, m_ovf, m_irq);
    end
    cfg_we = 0; cnt_we = 0; ovf_clr = 0;
  endtask

  task automatic set_cfg(logic [7:0] code, logic [7:0] um, logic [7:0] thr,
                         bit ed, bit iv, bit os, bit usr, bit ie, bit en, string tag);
    cfg_code = code; cfg_umask = um; cfg_thr = thr; cfg_edge = ed; cfg_inv = iv;
    cfg_os = os; cfg_usr = usr; cfg_ie = ie; cfg_en = en; cfg_we = 1;
    step(tag);
  endtask

  task automatic rand_run(int n, bit rand_priv, string tag);
    for (int i = 0; i < n; i++) begin
      evt_in = {$urandom, $urandom};
      if (rand_priv) priv_lvl = 2'($urandom);
      step(tag);
    end
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1 rst = 0;
    // R11 reset state
    n_tests++;
    if (cnt_rdata !== '0 || ovf_flag !== 0 || irq !== 0) begin
      n_fail++;
      $display("FAIL R11 reset: cnt=%0h ovf=%0b irq=%0b expected 0 0 0", cnt_rdata, ovf_flag, irq);
    end
    rand_run(5, 1, "R11 disabled hold");

    // R1/R2: sum mode across groups and masks
    set_cfg(8'd0, 8'hFF, 8'd0, 0, 0, 1, 1, 0, 1, "R11 cfg write adds nothing");
    rand_run(20, 0, "R2 sum all lanes");
    set_cfg(8'd2, 8'h5A, 8'd0, 0, 0, 1, 1, 0, 1, "R1 cfg");
    rand_run(20, 0, "R1 group 2 mask 5A");
    set_cfg(8'd3, 8'h81, 8'd0, 0, 0, 1, 1, 0, 1, "R1 cfg");
    rand_run(10, 0, "R1 group 3 end lanes");
    set_cfg(8'd7, 8'hFF, 8'd0, 0, 0, 1, 1, 0, 1, "R1 cfg");
    rand_run(10, 0, "R1 out of range code");
    set_cfg(8'd1, 8'hFF, 8'd0, 1, 1, 1, 1, 0, 1, "R2 cfg");
    rand_run(20, 0, "R2 inv edge ignored");

    // R3 threshold, including equality boundary
    set_cfg(8'd0, 8'h0F, 8'd3, 0, 0, 1, 1, 0, 1, "R3 cfg");
    rand_run(30, 0, "R3 threshold ge");
    evt_in = '0; evt_in[5:0] = 6'b010101; step("R3 equal to threshold");
    evt_in = '0; evt_in[5:0] = 6'b000101; step("R3 below threshold");

    // R4 inverted
    set_cfg(8'd0, 8'h0F, 8'd3, 0, 1, 1, 1, 0, 1, "R4 cfg");
    rand_run(30, 0, "R4 inverted compare");
    evt_in = '0; evt_in[5:0] = 6'b010101; step("R4 equal not counted");

    // R5 edge: held true, then pulses
    set_cfg(8'd0, 8'h01, 8'd1, 1, 0, 1, 1, 0, 1, "R5 cfg");
    evt_in = '0; evt_in[0] = 1;
    for (int i = 0; i < 8; i++) step("R5 held condition");
    evt_in = '0; step("R5 low");
    evt_in[0] = 1; step("R5 new rise");
    rand_run(30, 0, "R5 random edges");

    // R10: rewrite cfg mid-burst and disable/enable
    evt_in = '0; evt_in[0] = 1;
    step("R10 held");
    set_cfg(8'd0, 8'h01, 8'd1, 1, 0, 1, 1, 0, 1, "R10 rewrite");
    step("R10 rise after rewrite");
    step("R10 hold");
    set_cfg(8'd0, 8'h01, 8'd1, 1, 0, 1, 1, 0, 0, "R10 disable");
    step("R10 disabled cycle");
    set_cfg(8'd0, 8'h01, 8'd1, 1, 0, 1, 1, 0, 1, "R10 enable");
    step("R10 rise after enable");

    // R6 privilege filter
    set_cfg(8'd1, 8'hFF, 8'd0, 0, 0, 1, 0, 0, 1, "R6 cfg");
    rand_run(25, 1, "R6 os only");
    set_cfg(8'd1, 8'hFF, 8'd0, 0, 0, 0, 1, 0, 1, "R6 cfg");
    rand_run(25, 1, "R6 usr only");
    set_cfg(8'd1, 8'hFF, 8'd2, 1, 0, 0, 1, 0, 1, "R6 cfg");
    rand_run(25, 1, "R6 edge with filter");

    // R7 default both
    set_cfg(8'd2, 8'hFF, 8'd0, 0, 0, 0, 0, 0, 1, "R7 cfg");
    rand_run(25, 1, "R7 neither enable");
    priv_lvl = 0;

    // R8 counter write
    cnt_wdata = 48'h1234_5678_9ABC; cnt_we = 1; evt_in = '1; step("R8 write drops increment");
    rand_run(10, 0, "R8 count after write");

    // R9 overflow and interrupt
    set_cfg(8'd0, 8'hFF, 8'd0, 0, 0, 1, 1, 1, 1, "R9 cfg");
    cnt_wdata = {CNT_W{1'b1}} - 48'd3; cnt_we = 1; step("R9 load near wrap");
    evt_in = '0; evt_in[1:0] = 2'd3; step("R9 reach all ones");
    evt_in[1:0] = 2'd1; step("R9 wrap sets flag");
    evt_in = '0; step("R9 flag sticky");
    ovf_clr = 1; step("R9 clear");
    cnt_wdata = {CNT_W{1'b1}}; cnt_we = 1; step("R9 reload");
    evt_in[1:0] = 2'd2; ovf_clr = 1; step("R9 carry beats clear");
    set_cfg(8'd0, 8'hFF, 8'd0, 0, 0, 1, 1, 0, 1, "R9 ie off masks irq");
    rand_run(10, 0, "R9 flag kept");
    ovf_clr = 1; step("R9 clear again");

    // mixed random configurations
    for (int k = 0; k < 40; k++) begin
      set_cfg(8'($urandom % 5), 8'($urandom), 8'($urandom % 6), 1'($urandom), 1'($urandom),
              1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom % 4 != 0), "R5 mixed cfg");
      rand_run(15, 1, "R3 R4 R5 R6 mixed");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule